// File: doc/BRIEF.md
# Ring Oscillator Frequency Measurement Controller

This block is the digital control and observe part of an on-chip process monitor. It can serve up to 64 ring-oscillator test structures. A select register chooses one oscillator. The block raises the enable of that oscillator alone. The chosen oscillator drives a shared daisy-chain line, and its signal arrives on `chain_in` already divided by the oscillator's own 4-stage ripple divider.

The block divides `chain_in` again in a ripple divider of `DIV_STAGES` stages (8 by default). It passes the result through a two-flop synchronizer into the reference-clock domain and detects rising edges there. While a measurement window is open, each detected edge increments a capture counter.

A start command resets a window timer. The timer then counts reference cycles. The window is open while the timer is at least the start time and below the stop time. When the timer reaches the stop time, a sticky done flag is set and the count is frozen. Software then computes the ring frequency as 2^(4+DIV_STAGES) × Fref × count / (stop − start). The delay of one gate is half of 1 / (frequency × number of ring stages).

Top module: `ro_meas_ctrl`

## Requirements
- R1: When the select register holds a value s below N_RO, `ro_en` has exactly bit s set. Reset leaves select at 0, so `ro_en` reads 1 after reset.
- R2: When the select value is N_RO or above, `ro_en` is all zeros. With the defaults these are the values 64 to 127.
- R3: A write to the select register clears the count, the done flag, the overflow flag and the busy state on the next clock edge. It also resets the second divider and the synchronizer.
- R4: After a start command, the count equals the number of rising edges of `chain_in` divided by 2^DIV_STAGES that are seen while the timer is in [start, stop). The timer is 0 in the first cycle after the command. Because of synchronizer latency, the count may differ by one from the ideal number of edges in the window.
- R5: When the stop value is less than or equal to the start value, a start command sets done, clears busy and leaves the count at 0, all within one clock edge. The window never opens.
- R6: Done is set when the timer reaches the stop value and stays set. The count holds its value until the next start command or select write.
- R7: The count saturates at all ones. A further edge in the window sets a sticky overflow flag instead of wrapping. The overflow flag is cleared by a start command or a select write.
- R8: The register map is as follows.

  | Address | Write | Read |
  |---|---|---|
  | 0 | select | select |
  | 1 | start time | start time |
  | 2 | stop time | stop time |
  | 3 | bit 0 set means start command | status: bit 0 done, bit 1 overflow, bit 2 busy |
  | 4 | ignored | count |

  Read data is combinational on the address.
- R9: A start command while a measurement is busy restarts it. The timer returns to 0, the count is cleared, and done arrives only after the full stop time counted from the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chain_in | input | 1 | Divided oscillator signal from the daisy chain, asynchronous |
| ro_en | output | N_RO | One enable per ring oscillator |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |

## Verification
Two events can fall in the same reference cycle: the capture counter reaching its full value and the window closing. This is provoked with a narrow-counter instance whose chain input is locked in phase to the reference clock. The divider is cleared by a select write before each run, so every run starts from the same phase. The stop time is then swept one cycle at a time past the point where the counter fills. The runs are judged against each other. Each extra window cycle may raise the count by at most one. Overflow may appear only with a full count, and once it has appeared it must remain for every longer window.

// File: rtl/ro_meas_pkg.sv
package ro_meas_pkg;

  typedef enum logic [2:0] {
    ADDR_SEL   = 3'd0,
    ADDR_START = 3'd1,
    ADDR_STOP  = 3'd2,
    ADDR_CMD   = 3'd3,
    ADDR_COUNT = 3'd4
  } reg_addr_e;

  localparam int STAT_DONE = 0;
  localparam int STAT_OVF  = 1;
  localparam int STAT_BUSY = 2;
  localparam int CMD_GO    = 0;

endpackage

// File: rtl/ro_en_decode.sv
module ro_en_decode #(
  parameter int N_RO  = 64,
  parameter int SEL_W = 7
) (
  input  logic [SEL_W-1:0] sel,
  output logic [N_RO-1:0]  en
);

  for (genvar g = 0; g < N_RO; g++) begin : g_en
    assign en[g] = (sel == SEL_W'(g));
  end

endmodule

// File: rtl/ro_ripple_div.sv
module ro_ripple_div #(
  parameter int STAGES = 8
) (
  input  logic sig_in,
  input  logic arst_n,
  output logic div_out
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stg_q;
    if (i == 0) begin : g_first
      always_ff @(posedge sig_in or negedge arst_n) begin
        if (!arst_n) stg_q <= 1'b0;
        else         stg_q <= ~stg_q;
      end
    end else begin : g_next
      always_ff @(negedge g_stage[i-1].stg_q or negedge arst_n) begin
        if (!arst_n) stg_q <= 1'b0;
        else         stg_q <= ~stg_q;
      end
    end
  end

  assign div_out = g_stage[STAGES-1].stg_q;

endmodule

// File: rtl/ro_edge_sync.sv
module ro_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic async_in,
  output logic rise
);

  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], async_in};
    if (clr) sh_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[1] & ~sh_q[2];

endmodule

// File: rtl/ro_window_ctrl.sv
module ro_window_ctrl #(
  parameter int CNT_W = 24,
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start_cmd,
  input  logic [TMR_W-1:0] start_val,
  input  logic [TMR_W-1:0] stop_val,
  input  logic             edge_rise,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             ovf,
  output logic             busy
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic             ovf_q, ovf_d;
  logic             win_open;

  assign win_open = run_q && (tmr_q >= start_val) && (tmr_q < stop_val);

  always_comb begin
    tmr_d  = tmr_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    if (clr) begin
      tmr_d  = '0;
      cnt_d  = '0;
      run_d  = 1'b0;
      done_d = 1'b0;
      ovf_d  = 1'b0;
    end else if (start_cmd) begin
      tmr_d = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
      if (stop_val > start_val) begin
        run_d  = 1'b1;
        done_d = 1'b0;
      end else begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end else if (run_q) begin
      if (tmr_q >= stop_val) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
      if (win_open && edge_rise) begin
        if (cnt_q == CNT_MAX) ovf_d = 1'b1;
        else                  cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign done  = done_q;
  assign ovf   = ovf_q;
  assign busy  = run_q;

  // R3: a select write clears the measurement state
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !done_q && !ovf_q && !run_q));

  // R4: no counting outside the window
  assert_no_count_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !start_cmd && !clr) |=> $stable(cnt_q));

  // R5: an empty window finishes at once with zero
  assert_empty_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !clr && (stop_val <= start_val)) |=> (done_q && !run_q && cnt_q == '0));

  // R6: the result is frozen once done
  assert_frozen_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_cmd && !clr) |=> ($stable(cnt_q) && done_q));

  // R7: overflow only with a saturated count
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ro_meas_ctrl.sv
module ro_meas_ctrl
  import ro_meas_pkg::*;
#(
  parameter int N_RO       = 64,
  parameter int DIV_STAGES = 8,
  parameter int CNT_W      = 24,
  parameter int TMR_W      = 24,
  parameter int DATA_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_in,
  output logic [N_RO-1:0]   ro_en,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int SEL_W = $clog2(N_RO) + 1;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [TMR_W-1:0] strt_q, strt_d;
  logic [TMR_W-1:0] stp_q, stp_d;
  logic             clr_q;
  logic             sel_wr;
  logic             go_cmd;
  logic             div_arst_n;
  logic             div_sig;
  logic             sync_rise;
  logic [CNT_W-1:0] cnt;
  logic             done, ovf, busy;

  assign sel_wr = reg_we && (reg_addr == ADDR_SEL);
  assign go_cmd = reg_we && (reg_addr == ADDR_CMD) && reg_wdata[CMD_GO];

  always_comb begin
    sel_d  = sel_q;
    strt_d = strt_q;
    stp_d  = stp_q;
    if (sel_wr) sel_d = reg_wdata[SEL_W-1:0];
    if (reg_we && reg_addr == ADDR_START) strt_d = reg_wdata[TMR_W-1:0];
    if (reg_we && reg_addr == ADDR_STOP)  stp_d  = reg_wdata[TMR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      strt_q <= '0;
      stp_q  <= '0;
      clr_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      strt_q <= strt_d;
      stp_q  <= stp_d;
      clr_q  <= sel_wr;
    end
  end

  ro_en_decode #(.N_RO(N_RO), .SEL_W(SEL_W)) u_dec (
    .sel (sel_q),
    .en  (ro_en)
  );

  assign div_arst_n = rst_n & ~clr_q;

  ro_ripple_div #(.STAGES(DIV_STAGES)) u_div (
    .sig_in  (chain_in),
    .arst_n  (div_arst_n),
    .div_out (div_sig)
  );

  ro_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sel_wr),
    .async_in (div_sig),
    .rise     (sync_rise)
  );

  ro_window_ctrl #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sel_wr),
    .start_cmd (go_cmd),
    .start_val (strt_q),
    .stop_val  (stp_q),
    .edge_rise (sync_rise),
    .count     (cnt),
    .done      (done),
    .ovf       (ovf),
    .busy      (busy)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_SEL:   reg_rdata = DATA_W'(sel_q);
      ADDR_START: reg_rdata = DATA_W'(strt_q);
      ADDR_STOP:  reg_rdata = DATA_W'(stp_q);
      ADDR_CMD: begin
        reg_rdata[STAT_DONE] = done;
        reg_rdata[STAT_OVF]  = ovf;
        reg_rdata[STAT_BUSY] = busy;
      end
      ADDR_COUNT: reg_rdata = DATA_W'(cnt);
      default:    reg_rdata = '0;
    endcase
  end

  // R1: never more than one oscillator enabled
  assert_onehot_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ro_en));

  // R1: a valid select enables its oscillator
  assert_sel_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q < SEL_W'(N_RO)) |-> ro_en[sel_q[SEL_W-2:0]]);

  // R2: out-of-range select enables nothing
  assert_no_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q >= SEL_W'(N_RO)) |-> (ro_en == '0));

endmodule

// File: tb/ro_meas_ctrl_tb.sv
`timescale 1ns/1ps
module ro_meas_ctrl_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic chain_m = 1'b0;
  real  chain_half = 1.0;
  always #(chain_half) chain_m = ~chain_m;

  logic [63:0] en_m;
  logic        we_m = 1'b0;
  logic [2:0]  addr_m = 3'd0;
  logic [23:0] wd_m = '0;
  logic [23:0] rd_m;

  logic [3:0]  en_s;
  logic        we_s = 1'b0;
  logic [2:0]  addr_s = 3'd0;
  logic [23:0] wd_s = '0;
  logic [23:0] rd_s;
  logic        chain_s;
  assign chain_s = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  ro_meas_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .chain_in(chain_m), .ro_en(en_m),
    .reg_we(we_m), .reg_addr(addr_m), .reg_wdata(wd_m), .reg_rdata(rd_m)
  );

  ro_meas_ctrl #(.N_RO(4), .DIV_STAGES(2), .CNT_W(4), .TMR_W(8), .DATA_W(24)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .chain_in(chain_s), .ro_en(en_s),
    .reg_we(we_s), .reg_addr(addr_s), .reg_wdata(wd_s), .reg_rdata(rd_s)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_m(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); we_m = 1'b1; addr_m = a; wd_m = d;
    @(negedge clk); we_m = 1'b0;
  endtask

  task automatic rd_m_t(input logic [2:0] a, output logic [23:0] d);
    addr_m = a; #0.5; d = rd_m;
  endtask

  task automatic wr_s(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); we_s = 1'b1; addr_s = a; wd_s = d;
    @(negedge clk); we_s = 1'b0;
  endtask

  task automatic rd_s_t(input logic [2:0] a, output logic [23:0] d);
    addr_s = a; #0.5; d = rd_s;
  endtask

  task automatic wait_done_m(output int cycles);
    logic [23:0] st;
    cycles = 0;
    forever begin
      rd_m_t(3'd3, st);
      if (st[0] || cycles > 8000) break;
      @(negedge clk); cycles++;
    end
  endtask

  task automatic t_reset();
    logic [23:0] d;
    @(negedge clk);
    check(en_m == 64'd1, "R1 reset enable", en_m, 1);
    rd_m_t(3'd3, d); check(d == 0, "R8 reset status", d, 0);
    rd_m_t(3'd4, d); check(d == 0, "R8 reset count", d, 0);
  endtask

  task automatic t_decode();
    logic [23:0] d;
    wr_m(3'd0, 24'd5);
    check(en_m == (64'd1 << 5), "R1 select 5", en_m, 64'd1 << 5);
    rd_m_t(3'd0, d); check(d == 5, "R8 select readback", d, 5);
    wr_m(3'd0, 24'd63);
    check(en_m == (64'd1 << 63), "R1 select 63", en_m, 64'd1 << 63);
    wr_m(3'd0, 24'd64);
    check(en_m == 64'd0, "R2 select 64", en_m, 0);
    wr_m(3'd0, 24'd127);
    check(en_m == 64'd0, "R2 select 127", en_m, 0);
  endtask

  task automatic t_measure(input real half, input int len, input int exp);
    logic [23:0] d;
    int cyc;
    chain_half = half;
    wr_m(3'd0, 24'd3);
    wr_m(3'd1, 24'd16);
    wr_m(3'd2, 24'(16 + len));
    rd_m_t(3'd1, d); check(d == 16, "R8 start readback", d, 16);
    rd_m_t(3'd2, d); check(d == 16 + len, "R8 stop readback", d, 16 + len);
    wr_m(3'd3, 24'd1);
    rd_m_t(3'd3, d); check(d[2] == 1'b1, "R8 busy after start", d[2], 1);
    wait_done_m(cyc);
    rd_m_t(3'd4, d);
    check(int'(d) >= exp - 1 && int'(d) <= exp + 1, "R4 window count", d, exp);
    rd_m_t(3'd3, d); check(d == 24'd1, "R6 done status", d, 1);
  endtask

  task automatic t_freeze();
    logic [23:0] c0, c1, st;
    rd_m_t(3'd4, c0);
    repeat (400) @(negedge clk);
    rd_m_t(3'd4, c1);
    check(c1 == c0, "R6 count frozen", c1, c0);
    rd_m_t(3'd3, st); check(st[0] == 1'b1, "R6 done sticky", st[0], 1);
  endtask

  task automatic t_restart();
    logic [23:0] d;
    int cyc;
    chain_half = 1.0;
    wr_m(3'd1, 24'd16);
    wr_m(3'd2, 24'd1296);
    wr_m(3'd3, 24'd1);
    repeat (600) @(negedge clk);
    rd_m_t(3'd3, d); check(d[2] == 1'b1, "R9 busy mid run", d[2], 1);
    wr_m(3'd3, 24'd1);
    wait_done_m(cyc);
    check(cyc >= 1290 && cyc <= 1300, "R9 restart duration", cyc, 1296);
    rd_m_t(3'd4, d);
    check(d >= 9 && d <= 11, "R9 restart count", d, 10);
  endtask

  task automatic t_empty();
    logic [23:0] d;
    wr_m(3'd1, 24'd100);
    wr_m(3'd2, 24'd100);
    wr_m(3'd3, 24'd1);
    rd_m_t(3'd3, d); check(d == 24'd1, "R5 equal bounds status", d, 1);
    rd_m_t(3'd4, d); check(d == 0, "R5 equal bounds count", d, 0);
    wr_m(3'd2, 24'd50);
    wr_m(3'd3, 24'd1);
    rd_m_t(3'd3, d); check(d == 24'd1, "R5 reversed bounds status", d, 1);
    repeat (200) @(negedge clk);
    rd_m_t(3'd4, d); check(d == 0, "R5 reversed bounds count", d, 0);
  endtask

  task automatic t_sel_clear();
    logic [23:0] d;
    t_measure(1.0, 1280, 10);
    wr_m(3'd0, 24'd7);
    rd_m_t(3'd3, d); check(d == 0, "R3 status cleared", d, 0);
    rd_m_t(3'd4, d); check(d == 0, "R3 count cleared", d, 0);
  endtask

  task automatic t_sweep();
    logic [23:0] c, st;
    int prev_c = 0;
    bit prev_o = 0;
    bit step_ok = 1;
    for (int s = 1; s <= 80; s++) begin
      wr_s(3'd0, 24'd1);
      wr_s(3'd1, 24'd0);
      wr_s(3'd2, 24'(s));
      wr_s(3'd3, 24'd1);
      for (int k = 0; k < 200; k++) begin
        rd_s_t(3'd3, st);
        if (st[0]) break;
        @(negedge clk);
      end
      rd_s_t(3'd4, c);
      if (s == 1) check(c == 0, "R4 one cycle window", c, 0);
      if (st[1]) check(c == 15, "R7 overflow with full count", c, 15);
      if (prev_o) check(st[1] && c == 15, "R7 overflow persists", c, 15);
      else if (!(int'(c) == prev_c || int'(c) == prev_c + 1)) step_ok = 0;
      prev_c = int'(c);
      prev_o = st[1];
    end
    check(step_ok, "R4 count step per window cycle", step_ok, 1);
    check(prev_o && prev_c == 15, "R7 saturated at long window", prev_c, 15);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_measure(1.0, 1280, 10);
    t_freeze();
    t_measure(2.0, 2048, 8);
    t_restart();
    t_empty();
    t_sel_clear();
    t_sweep();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule